// File: doc/BRIEF.md
# Legacy Command Register Translation Unit

This block sits in front of the native control registers of a video palette and DAC controller. A host written for an older register layout issues byte writes through a 5-bit register-select bus. The block holds two emulated command registers, here called the mode register (select 5'b11001) and the extended register (select 5'b11010). It turns every write to them into updates of bits spread across four native indirect registers: clock selection, cursor control, multiplexer control 2 and miscellaneous control.

The extended register is only reachable while the host's base command register has its bit 7 set. That bit belongs to logic outside this block and arrives on `extRegEn`. The native registers can also be loaded directly, a whole byte at a time, through a separate native write port. The four native values and the upper two cursor-RAM address bits are driven out continuously. The emulated registers can be read back combinationally through `rdData`.

Top module: `legacy_cmd_xlate`

## Requirements
- R1: A write with `regSel` = 5'b11001 stores `wrData` in the mode register. Reading that select returns the stored byte with bit 6 forced to 0.
- R2: Select 5'b11010 reaches the extended register only while `extRegEn` is 1. With `extRegEn` at 0, a write there leaves the extended register, `cursorAddrHi` and clock-selection bit 4 unchanged, and a read there returns 0.
- R3: Every mode-register write clears bits 2 and 1 of clock selection and bits 5 and 2 of cursor control.
- R4: On a mode-register write, bit 0 goes to cursor-control bit 4, bit 1 to cursor-control bit 6, and bit 4 to clock-selection bit 0.
- R5: Mode-register bit 5 (0 = VGA mode, 1 = non-VGA mode) is written to both multiplexer-control-2 bit 7 and miscellaneous-control bit 4.
- R6: Mode-register bit 6 is copied to clock-selection bit 3. Bits 2, 3 and 7 change no native bit.
- R7: An enabled extended-register write copies bit 3 (clock doubler enable) to clock-selection bit 4 and bits 1:0 to `cursorAddrHi` (cursor address bits 9:8). Bit 2 changes no native bit. A read returns bits 7:4 as 0.
- R8: While `rstN` is 0, both emulated registers, all four native registers and `cursorAddrHi` are 0.
- R9: Updates become visible right after the rising clock edge that samples the strobe. Writes to any other select, and cycles with no strobe, change no output.
- R10: `nativeWrEn` loads `nativeWrData` into the native register picked by `nativeSel` (0 clock selection, 1 cursor control, 2 multiplexer control 2, 3 miscellaneous control). In the same cycle as a legacy write, the legacy side-effect clears apply over the native byte, and the mapped legacy bits apply over both.
- R11: A read at any select other than the two emulated registers returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 5 | Legacy register select |
| wrEn | input | 1 | Legacy write strobe |
| wrData | input | 8 | Legacy write byte |
| extRegEn | input | 1 | Bit 7 of the host's base command register; unlocks the extended register |
| nativeWrEn | input | 1 | Direct native register write strobe |
| nativeSel | input | 2 | Native register index for direct writes |
| nativeWrData | input | 8 | Direct native write byte |
| rdData | output | 8 | Readback of the emulated register at `regSel` |
| clkSelReg | output | 8 | Native clock-selection register |
| curCtlReg | output | 8 | Native cursor-control register |
| muxCtl2Reg | output | 8 | Native multiplexer-control-2 register |
| miscCtlReg | output | 8 | Native miscellaneous-control register |
| cursorAddrHi | output | 2 | Cursor RAM address bits 9:8 |

## Verification
The bench preloads the native registers with varied patterns. It then sweeps all 256 mode-register and extended-register values, so a wrong bit route, or a clear that hits the wrong position, shows up as a native bit that differs from its preloaded value. Extended writes are repeated with the gate closed: a design that ignores `extRegEn` moves `cursorAddrHi` or clock-selection bit 4. Legacy and native writes are issued in the same cycle. A design with the wrong merge order loses either the mapped bits or the clears. A reset in the middle of the run catches registers that leave out the asynchronous clear.

// File: rtl/legacy_cmd_xlate_pkg.sv
package legacy_cmd_xlate_pkg;

  localparam int BYTE_W    = 8;
  localparam int NATIVE_N  = 4;
  localparam int NAT_IDX_W = $clog2(NATIVE_N);

  // native register indices (also the nativeSel encoding)
  localparam int IDX_CLKSEL  = 0;
  localparam int IDX_CURCTL  = 1;
  localparam int IDX_MUXCTL2 = 2;
  localparam int IDX_MISC    = 3;

  // mode register field positions
  localparam int MODE_CURMODE = 0;
  localparam int MODE_CUREN   = 1;
  localparam int MODE_CLKIN   = 4;
  localparam int MODE_NONVGA  = 5;
  localparam int MODE_RSVD    = 6;

  // extended register field positions
  localparam int EXT_ADDR_LO = 0;
  localparam int EXT_DBL     = 3;

  // native destination bit positions
  localparam int CLK_IN_BIT   = 0;
  localparam int CLK_CLR_A    = 1;
  localparam int CLK_CLR_B    = 2;
  localparam int CLK_RSVD_BIT = 3;
  localparam int CLK_DBL_BIT  = 4;
  localparam int CUR_CLR_A    = 2;
  localparam int CUR_CLR_B    = 5;
  localparam int CUR_MODE_BIT = 4;
  localparam int CUR_EN_BIT   = 6;
  localparam int MUX_VGA_BIT  = 7;
  localparam int MISC_VGA_BIT = 4;

  // readback masks
  localparam logic [BYTE_W-1:0] MODE_RD_MASK = 8'hBF;
  localparam logic [BYTE_W-1:0] EXT_RD_MASK  = 8'h0F;

  typedef struct packed {
    logic                 wrMode;
    logic                 wrExt;
    logic                 rdMode;
    logic                 rdExt;
    logic                 nativeWr;
    logic [NAT_IDX_W-1:0] nativeIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/legacy_cmd_xlate_ctrl.sv
module legacy_cmd_xlate_ctrl
  import legacy_cmd_xlate_pkg::*;
#(
  parameter int               SEL_W     = 5,
  parameter logic [SEL_W-1:0] MODE_SEL  = 5'b11001,
  parameter logic [SEL_W-1:0] EXT_SEL   = 5'b11010
) (
  input  logic [SEL_W-1:0]     regSel,
  input  logic                 wrEn,
  input  logic                 extRegEn,
  input  logic                 nativeWrEn,
  input  logic [NAT_IDX_W-1:0] nativeSel,
  output ctrlStrobes_t         strb
);

  logic hitMode;
  logic hitExt;

  always_comb begin
    hitMode = (regSel == MODE_SEL);
    // the extended register only decodes while the base register unlocks it
    hitExt  = (regSel == EXT_SEL) && extRegEn;

    strb           = '0;
    strb.wrMode    = wrEn && hitMode;
    strb.wrExt     = wrEn && hitExt;
    strb.rdMode    = hitMode;
    strb.rdExt     = hitExt;
    strb.nativeWr  = nativeWrEn;
    strb.nativeIdx = nativeSel;
  end

endmodule

// File: rtl/legacy_cmd_xlate_dp.sv
module legacy_cmd_xlate_dp
  import legacy_cmd_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] nativeWrData,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] nativeQ [NATIVE_N],
  output logic [1:0]        cursorAddrHi
);

  logic [BYTE_W-1:0] modeQ;
  logic [BYTE_W-1:0] extQ;
  logic [BYTE_W-1:0] setMask [NATIVE_N];
  logic [BYTE_W-1:0] setVal  [NATIVE_N];
  logic [BYTE_W-1:0] clrMask [NATIVE_N];

  // emulated registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (strb.wrMode) begin
      modeQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extQ <= '0;
    end else if (strb.wrExt) begin
      extQ <= wrData;
    end
  end

  // fan-out of one legacy write into per-native set and clear masks
  always_comb begin
    for (int k = 0; k < NATIVE_N; k++) begin
      setMask[k] = '0;
      setVal[k]  = '0;
      clrMask[k] = '0;
    end
    if (strb.wrMode) begin
      clrMask[IDX_CLKSEL][CLK_CLR_A]   = 1'b1;
      clrMask[IDX_CLKSEL][CLK_CLR_B]   = 1'b1;
      clrMask[IDX_CURCTL][CUR_CLR_A]   = 1'b1;
      clrMask[IDX_CURCTL][CUR_CLR_B]   = 1'b1;

      setMask[IDX_CLKSEL][CLK_IN_BIT]   = 1'b1;
      setVal[IDX_CLKSEL][CLK_IN_BIT]    = wrData[MODE_CLKIN];
      setMask[IDX_CLKSEL][CLK_RSVD_BIT] = 1'b1;
      setVal[IDX_CLKSEL][CLK_RSVD_BIT]  = wrData[MODE_RSVD];

      setMask[IDX_CURCTL][CUR_MODE_BIT] = 1'b1;
      setVal[IDX_CURCTL][CUR_MODE_BIT]  = wrData[MODE_CURMODE];
      setMask[IDX_CURCTL][CUR_EN_BIT]   = 1'b1;
      setVal[IDX_CURCTL][CUR_EN_BIT]    = wrData[MODE_CUREN];

      setMask[IDX_MUXCTL2][MUX_VGA_BIT] = 1'b1;
      setVal[IDX_MUXCTL2][MUX_VGA_BIT]  = wrData[MODE_NONVGA];
      setMask[IDX_MISC][MISC_VGA_BIT]   = 1'b1;
      setVal[IDX_MISC][MISC_VGA_BIT]    = wrData[MODE_NONVGA];
    end
    if (strb.wrExt) begin
      setMask[IDX_CLKSEL][CLK_DBL_BIT] = 1'b1;
      setVal[IDX_CLKSEL][CLK_DBL_BIT]  = wrData[EXT_DBL];
    end
  end

  // native registers: direct byte, then clears, then mapped bits
  for (genvar k = 0; k < NATIVE_N; k++) begin : gNative
    logic [BYTE_W-1:0] baseVal;
    logic [BYTE_W-1:0] nextVal;

    always_comb begin
      baseVal = (strb.nativeWr && (strb.nativeIdx == NAT_IDX_W'(k)))
                ? nativeWrData : nativeQ[k];
      nextVal = ((baseVal & ~clrMask[k]) & ~setMask[k]) | (setVal[k] & setMask[k]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nativeQ[k] <= '0;
      end else begin
        nativeQ[k] <= nextVal;
      end
    end
  end

  assign cursorAddrHi = extQ[EXT_ADDR_LO +: 2];

  always_comb begin
    if (strb.rdMode) begin
      rdData = modeQ & MODE_RD_MASK;
    end else if (strb.rdExt) begin
      rdData = extQ & EXT_RD_MASK;
    end else begin
      rdData = '0;
    end
  end

endmodule

// File: rtl/legacy_cmd_xlate.sv
module legacy_cmd_xlate
  import legacy_cmd_xlate_pkg::*;
#(
  parameter int               SEL_W    = 5,
  parameter logic [SEL_W-1:0] MODE_SEL = 5'b11001,
  parameter logic [SEL_W-1:0] EXT_SEL  = 5'b11010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     regSel,
  input  logic                 wrEn,
  input  logic [BYTE_W-1:0]    wrData,
  input  logic                 extRegEn,
  input  logic                 nativeWrEn,
  input  logic [NAT_IDX_W-1:0] nativeSel,
  input  logic [BYTE_W-1:0]    nativeWrData,
  output logic [BYTE_W-1:0]    rdData,
  output logic [BYTE_W-1:0]    clkSelReg,
  output logic [BYTE_W-1:0]    curCtlReg,
  output logic [BYTE_W-1:0]    muxCtl2Reg,
  output logic [BYTE_W-1:0]    miscCtlReg,
  output logic [1:0]           cursorAddrHi
);

  ctrlStrobes_t      strb;
  logic [BYTE_W-1:0] nativeQ [NATIVE_N];

  legacy_cmd_xlate_ctrl #(
    .SEL_W   (SEL_W),
    .MODE_SEL(MODE_SEL),
    .EXT_SEL (EXT_SEL)
  ) uCtrl (
    .regSel    (regSel),
    .wrEn      (wrEn),
    .extRegEn  (extRegEn),
    .nativeWrEn(nativeWrEn),
    .nativeSel (nativeSel),
    .strb      (strb)
  );

  legacy_cmd_xlate_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .nativeWrData(nativeWrData),
    .rdData      (rdData),
    .nativeQ     (nativeQ),
    .cursorAddrHi(cursorAddrHi)
  );

  assign clkSelReg  = nativeQ[IDX_CLKSEL];
  assign curCtlReg  = nativeQ[IDX_CURCTL];
  assign muxCtl2Reg = nativeQ[IDX_MUXCTL2];
  assign miscCtlReg = nativeQ[IDX_MISC];

endmodule

// File: rtl/legacy_cmd_xlate_chk.sv
module legacy_cmd_xlate_chk #(
  parameter int               SEL_W    = 5,
  parameter logic [SEL_W-1:0] MODE_SEL = 5'b11001,
  parameter logic [SEL_W-1:0] EXT_SEL  = 5'b11010
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] regSel,
  input logic             wrEn,
  input logic [7:0]       wrData,
  input logic             extRegEn,
  input logic             nativeWrEn,
  input logic [7:0]       rdData,
  input logic [7:0]       clkSelReg,
  input logic [7:0]       curCtlReg,
  input logic [7:0]       muxCtl2Reg,
  input logic [7:0]       miscCtlReg,
  input logic [1:0]       cursorAddrHi
);

  assert_mode_rd_rsvd_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == MODE_SEL) |-> (rdData[6] == 1'b0));

  assert_ext_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regSel == EXT_SEL) && !extRegEn && !nativeWrEn)
      |=> ($stable(cursorAddrHi) && $stable(clkSelReg[4])));

  assert_side_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regSel == MODE_SEL) && !nativeWrEn)
      |=> (clkSelReg[2:1] == 2'b00 && curCtlReg[5] == 1'b0 && curCtlReg[2] == 1'b0));

  assert_vga_dual_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regSel == MODE_SEL))
      |=> (muxCtl2Reg[7] == $past(wrData[5]) && miscCtlReg[4] == $past(wrData[5])));

  assert_ext_map_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regSel == EXT_SEL) && extRegEn)
      |=> (cursorAddrHi == $past(wrData[1:0]) && clkSelReg[4] == $past(wrData[3])));

  assert_ext_rd_rsvd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == EXT_SEL) |-> (rdData[7:4] == 4'h0));

  assert_reset_zero_R8: assert property (@(posedge clk)
    !rstN |-> (clkSelReg == 8'h00 && curCtlReg == 8'h00 && muxCtl2Reg == 8'h00
               && miscCtlReg == 8'h00 && cursorAddrHi == 2'b00));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !nativeWrEn)
      |=> ($stable(clkSelReg) && $stable(curCtlReg) && $stable(muxCtl2Reg)
           && $stable(miscCtlReg) && $stable(cursorAddrHi)));

  assert_other_rd_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((regSel != MODE_SEL) && (regSel != EXT_SEL)) |-> (rdData == 8'h00));

endmodule

bind legacy_cmd_xlate legacy_cmd_xlate_chk #(
  .SEL_W   (SEL_W),
  .MODE_SEL(MODE_SEL),
  .EXT_SEL (EXT_SEL)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .regSel      (regSel),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .extRegEn    (extRegEn),
  .nativeWrEn  (nativeWrEn),
  .rdData      (rdData),
  .clkSelReg   (clkSelReg),
  .curCtlReg   (curCtlReg),
  .muxCtl2Reg  (muxCtl2Reg),
  .miscCtlReg  (miscCtlReg),
  .cursorAddrHi(cursorAddrHi)
);

// File: tb/legacy_cmd_xlate_test.sv
module legacy_cmd_xlate_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MODE_SEL = 5'b11001;
  localparam logic [4:0] EXT_SEL  = 5'b11010;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] regSel;
  logic       wrEn;
  logic [7:0] wrData;
  logic       extRegEn;
  logic       nativeWrEn;
  logic [1:0] nativeSel;
  logic [7:0] nativeWrData;
  logic [7:0] rdData;
  logic [7:0] clkSelReg;
  logic [7:0] curCtlReg;
  logic [7:0] muxCtl2Reg;
  logic [7:0] miscCtlReg;
  logic [1:0] cursorAddrHi;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [7:0] expNat [4];
  logic [7:0] expMode;
  logic [7:0] expExt;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_cmd_xlate uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .extRegEn(extRegEn), .nativeWrEn(nativeWrEn), .nativeSel(nativeSel),
    .nativeWrData(nativeWrData), .rdData(rdData), .clkSelReg(clkSelReg),
    .curCtlReg(curCtlReg), .muxCtl2Reg(muxCtl2Reg), .miscCtlReg(miscCtlReg),
    .cursorAddrHi(cursorAddrHi)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 4; k++) expNat[k] = 8'h00;
    expMode = 8'h00;
    expExt  = 8'h00;
  endtask

  task automatic modelApply(bit leg, logic [4:0] sel, logic [7:0] d, bit ext,
                            bit nat, logic [1:0] idx, logic [7:0] nd);
    if (nat) expNat[idx] = nd;
    if (leg && sel == MODE_SEL) begin
      expMode = d;
      expNat[0][1] = 1'b0; expNat[0][2] = 1'b0;
      expNat[1][2] = 1'b0; expNat[1][5] = 1'b0;
      expNat[0][0] = d[4]; expNat[0][3] = d[6];
      expNat[1][4] = d[0]; expNat[1][6] = d[1];
      expNat[2][7] = d[5]; expNat[3][4] = d[5];
    end
    if (leg && sel == EXT_SEL && ext) begin
      expExt = d;
      expNat[0][4] = d[3];
    end
  endtask

  // called between edges with strobes low
  task automatic checkAll(string phase);
    check("R3 R4 R6 R7 R10", {phase, " clkSel"}, clkSelReg, expNat[0]);
    check("R3 R4 R10", {phase, " curCtl"}, curCtlReg, expNat[1]);
    check("R5 R10", {phase, " muxCtl2"}, muxCtl2Reg, expNat[2]);
    check("R5 R10", {phase, " miscCtl"}, miscCtlReg, expNat[3]);
    check("R7", {phase, " cursorAddrHi"}, {6'b0, cursorAddrHi}, {6'b0, expExt[1:0]});
    regSel = MODE_SEL; #1;
    check("R1", {phase, " mode readback"}, rdData, expMode & 8'hBF);
    regSel = EXT_SEL; #1;
    check("R2 R7", {phase, " ext readback"}, rdData, extRegEn ? (expExt & 8'h0F) : 8'h00);
    regSel = 5'd0; #1;
    check("R11", {phase, " other readback"}, rdData, 8'h00);
  endtask

  task automatic doOp(string phase, bit leg, logic [4:0] sel, logic [7:0] d, bit ext,
                      bit nat, logic [1:0] idx, logic [7:0] nd);
    @(negedge clk);
    regSel = sel; wrEn = leg; wrData = d; extRegEn = ext;
    nativeWrEn = nat; nativeSel = idx; nativeWrData = nd;
    @(posedge clk); #1;
    wrEn = 1'b0; nativeWrEn = 1'b0;
    modelApply(leg, sel, d, ext, nat, idx, nd);
    checkAll(phase);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regSel = '0; wrEn = 1'b0; wrData = '0; extRegEn = 1'b0;
    nativeWrEn = 1'b0; nativeSel = '0; nativeWrData = '0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R8: state held at zero under reset
    checkAll("R8 reset");
    @(negedge clk);
    rstN = 1'b1;

    // mode register sweep over varied native preloads (R1 R3 R4 R5 R6)
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 4; k++)
        doOp("preload", 0, 5'd0, 8'h00, 0, 1, 2'(k), 8'(i * 29 + k * 83 + 7));
      doOp("mode sweep", 1, MODE_SEL, 8'(i), 0, 0, 2'd0, 8'h00);
    end

    // extended register enabled sweep (R7)
    for (int i = 0; i < 256; i++)
      doOp("ext enabled", 1, EXT_SEL, 8'(i), 1, 0, 2'd0, 8'h00);

    // extended register gated off: writes ignored (R2)
    for (int i = 0; i < 256; i++)
      doOp("ext gated", 1, EXT_SEL, 8'(~i), 0, 0, 2'd0, 8'h00);

    // other selects and idle cycles change nothing (R9 R11)
    for (int s = 0; s < 32; s++)
      if (5'(s) != MODE_SEL && 5'(s) != EXT_SEL)
        doOp("other select R9", 1, 5'(s), 8'hA5, 1, 0, 2'd0, 8'h00);
    doOp("idle R9", 0, MODE_SEL, 8'hFF, 1, 0, 2'd0, 8'h00);

    // same-cycle native and legacy writes (R10)
    for (int i = 0; i < 256; i++)
      doOp("merge mode R10", 1, MODE_SEL, 8'(i), 1, 1, 2'(i), 8'(~i));
    for (int i = 0; i < 64; i++)
      doOp("merge ext R10", 1, EXT_SEL, 8'(i * 5), 1, 1, 2'd0, 8'(i * 7 + 1));

    // mid-run asynchronous reset (R8)
    @(negedge clk);
    rstN = 1'b0; #1;
    modelReset();
    checkAll("R8 midrun");
    @(negedge clk);
    rstN = 1'b1;
    doOp("after reset", 1, MODE_SEL, 8'h3F, 1, 0, 2'd0, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule